// File: doc/BRIEF.md
# ALU Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order integer pipeline. It decides, for each of the two ALU operands, whether the value read from the register file is stale. If it is, the block substitutes a result that is still travelling down the pipeline. Two producer stages are considered:

- the instruction one step ahead, whose ALU result is held in the EX/MEM register;
- the instruction two steps ahead, whose writeback value is held in the MEM/WB register.

The decision is purely combinational. It settles within the same execute cycle from the register numbers and write enables already held in the pipeline registers.

The block is made of three parts. A selector produces one 2-bit select per operand. A pair of operand multiplexers applies those selects to three 32-bit candidates: the register-file read, the EX/MEM result and the MEM/WB value. A top level wires these parts together and exposes both the selects and the chosen operands. Register-file access, the ALU itself, load-use stalls and branch handling belong to neighbouring blocks.

Top module: `exop_bypass`

## Requirements
- R1: Each select uses the encoding 2'b00 = register-file value, 2'b10 = EX/MEM result, 2'b01 = MEM/WB value; 2'b11 never appears.
- R2: Operand A select is 2'b10 whenever the EX/MEM write enable is 1, the EX/MEM destination is nonzero, and the EX/MEM destination equals the ID/EX first source number.
- R3: Operand B select is 2'b10 under the same conditions, with the ID/EX second source number in place of the first.
- R4: An operand select is 2'b01 when the MEM/WB write enable is 1, the MEM/WB destination is nonzero and equals that operand's source number, and the EX/MEM condition for that operand is false.
- R5: When both producer stages match the same operand, the EX/MEM result (2'b10) is chosen over the MEM/WB value.
- R6: A producer stage whose write enable is 0 is never selected, even when the register numbers match.
- R7: A destination of register 0 never causes forwarding from either stage; the select stays at the register-file value unless the other stage forwards.
- R8: The two operand selects are computed independently. Both may be active in the same cycle, including when both source numbers are the same register.
- R9: Each operand output equals the candidate named by its select: the register-file read for 2'b00, the EX/MEM result for 2'b10, and the MEM/WB value for 2'b01.
- R10: For three back-to-back writes to the same register, the consumer's operand is taken from EX/MEM. In this case both stages match with write enable 1, and the EX/MEM value is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_src_a | input | 5 | ID/EX first source register number (operand A) |
| id_src_b | input | 5 | ID/EX second source register number (operand B) |
| exm_dst | input | 5 | EX/MEM destination register number |
| exm_wen | input | 1 | EX/MEM register write enable |
| mwb_dst | input | 5 | MEM/WB destination register number |
| mwb_wen | input | 1 | MEM/WB register write enable |
| rf_val_a | input | 32 | Register-file read value for operand A |
| rf_val_b | input | 32 | Register-file read value for operand B |
| exm_val | input | 32 | ALU result held in EX/MEM |
| mwb_val | input | 32 | Writeback value held in MEM/WB |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| opnd_a | output | 32 | Chosen operand A |
| opnd_b | output | 32 | Chosen operand B |

## Verification
Random register numbers are drawn from a narrow range (0 to 3), so that matches on one stage, on both stages and on register 0 occur often. These runs separate correct priority from a selector that lets the older stage win. Directed cases isolate each gating term one at a time:

- a write enable cleared while the numbers match;
- a register-0 destination with the enable set;
- the same source number on both operands;
- the triple-write chain to one register.

These cases catch a selector that drops a single term of the match condition. All four candidate data words are kept distinct, so a wrong select value shows up as a wrong operand and cannot be hidden by equal data.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;

  // producer stage hit: enabled, not register zero, same number as the source
  function automatic logic stage_hit(input logic wen,
                                     input logic [4:0] dst,
                                     input logic [4:0] src);
    return wen && (dst != 5'd0) && (dst == src);
  endfunction

  // newest producer first
  function automatic fwd_sel_e pick_src(input logic hit_new, input logic hit_old);
    if (hit_new)      return FWD_EXM;
    else if (hit_old) return FWD_MWB;
    else              return FWD_RF;
  endfunction

endpackage

// File: rtl/fwd_hit_det.sv
module fwd_hit_det #(
  parameter int RW = 5
) (
  input  logic          wen,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] src,
  output logic          hit
);
  logic dst_live;
  assign dst_live = wen && (dst != '0);
  assign hit      = dst_live && (dst == src);
endmodule

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
  import fwd_pkg::*;
#(
  parameter int RW   = 5,
  parameter int NSRC = 2
) (
  input  logic [RW-1:0] src   [NSRC],
  input  logic [RW-1:0] exm_dst,
  input  logic          exm_wen,
  input  logic [RW-1:0] mwb_dst,
  input  logic          mwb_wen,
  output fwd_sel_e      sel   [NSRC]
);
  logic exm_hit [NSRC];
  logic mwb_hit [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    fwd_hit_det #(.RW(RW)) u_exm (
      .wen(exm_wen), .dst(exm_dst), .src(src[i]), .hit(exm_hit[i])
    );
    fwd_hit_det #(.RW(RW)) u_mwb (
      .wen(mwb_wen), .dst(mwb_dst), .src(src[i]), .hit(mwb_hit[i])
    );
    assign sel[i] = pick_src(exm_hit[i], mwb_hit[i]);

    always_comb begin
      // R1
      sel_legal_chk: assert (sel[i] != fwd_sel_e'(2'b11))
        else $error("select %0d takes reserved code", i);
      // R6
      idle_stage_chk: assert (!((sel[i] == FWD_EXM && !exm_wen) ||
                                (sel[i] == FWD_MWB && !mwb_wen)))
        else $error("select %0d points at a non-writing stage", i);
      // R7
      zero_dst_chk: assert (!((sel[i] == FWD_EXM && exm_dst == '0) ||
                              (sel[i] == FWD_MWB && mwb_dst == '0)))
        else $error("select %0d forwards register zero", i);
      // R5
      newest_wins_chk: assert (!(exm_hit[i] && sel[i] != FWD_EXM))
        else $error("select %0d skipped the newer producer", i);
    end
  end
endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  fwd_sel_e      sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] exm_val,
  input  logic [DW-1:0] mwb_val,
  output logic [DW-1:0] opnd
);
  always_comb begin
    unique case (sel)
      FWD_EXM: opnd = exm_val;
      FWD_MWB: opnd = mwb_val;
      default: opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/exop_bypass.sv
module exop_bypass
  import fwd_pkg::*;
#(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic [RW-1:0] exm_dst,
  input  logic          exm_wen,
  input  logic [RW-1:0] mwb_dst,
  input  logic          mwb_wen,
  input  logic [DW-1:0] rf_val_a,
  input  logic [DW-1:0] rf_val_b,
  input  logic [DW-1:0] exm_val,
  input  logic [DW-1:0] mwb_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);
  localparam int NSRC = 2;

  logic [RW-1:0] src_num [NSRC];
  fwd_sel_e      src_sel [NSRC];
  logic [DW-1:0] rf_in   [NSRC];
  logic [DW-1:0] opnd    [NSRC];

  assign src_num[0] = id_src_a;
  assign src_num[1] = id_src_b;
  assign rf_in[0]   = rf_val_a;
  assign rf_in[1]   = rf_val_b;

  fwd_sel_unit #(.RW(RW), .NSRC(NSRC)) u_sel (
    .src(src_num), .exm_dst(exm_dst), .exm_wen(exm_wen),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .sel(src_sel)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_mux
    opnd_mux #(.DW(DW)) u_mux (
      .sel(src_sel[i]), .rf_val(rf_in[i]), .exm_val(exm_val),
      .mwb_val(mwb_val), .opnd(opnd[i])
    );

    always_comb begin
      // R9
      opnd_route_chk: assert (
        (src_sel[i] == FWD_EXM) ? (opnd[i] == exm_val) :
        (src_sel[i] == FWD_MWB) ? (opnd[i] == mwb_val) :
                                  (opnd[i] == rf_in[i]))
        else $error("operand %0d does not follow its select", i);
    end
  end

  assign sel_a  = src_sel[0];
  assign sel_b  = src_sel[1];
  assign opnd_a = opnd[0];
  assign opnd_b = opnd[1];
endmodule

// File: tb/sim_exop_bypass.sv
module sim_exop_bypass;
  localparam int CLK_PERIOD = 10;
  localparam int NRAND = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  id_src_a, id_src_b, exm_dst, mwb_dst;
  logic        exm_wen, mwb_wen;
  logic [31:0] rf_val_a, rf_val_b, exm_val, mwb_val;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  exop_bypass u0 (
    .id_src_a(id_src_a), .id_src_b(id_src_b), .exm_dst(exm_dst), .exm_wen(exm_wen),
    .mwb_dst(mwb_dst), .mwb_wen(mwb_wen), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .exm_val(exm_val), .mwb_val(mwb_val), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // expected select, written as a decision per stage
  function automatic logic [1:0] want_sel(input logic [4:0] s);
    logic take_new, take_old;
    take_new = 1'b0;
    take_old = 1'b0;
    if (exm_wen === 1'b1 && exm_dst !== 5'd0 && exm_dst === s) take_new = 1'b1;
    if (mwb_wen === 1'b1 && mwb_dst !== 5'd0 && mwb_dst === s) take_old = 1'b1;
    if (take_new) return 2'b10;
    if (take_old) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_val(input logic [1:0] s, input logic [31:0] rf);
    if (s == 2'b10) return exm_val;
    if (s == 2'b01) return mwb_val;
    return rf;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] ed, input logic ew,
                       input logic [4:0] md, input logic mw);
    @(negedge clk);
    id_src_a = sa; id_src_b = sb;
    exm_dst = ed;  exm_wen = ew;
    mwb_dst = md;  mwb_wen = mw;
    rf_val_a = $urandom | 32'h1; rf_val_b = $urandom | 32'h2;
    exm_val  = 32'hE000_0000 | ($urandom & 32'hFFFF);
    mwb_val  = 32'hB000_0000 | ($urandom & 32'hFFFF);
    #(CLK_PERIOD/4);
  endtask

  // full comparison of both selects and both operands
  task automatic full_check(input string req);
    logic [1:0] ea, eb;
    ea = want_sel(id_src_a);
    eb = want_sel(id_src_b);
    chk({req, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
    chk({req, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
    chk({req, " opnd_a R9"}, opnd_a, want_val(ea, rf_val_a));
    chk({req, " opnd_b R9"}, opnd_b, want_val(eb, rf_val_b));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R1 idle state: nothing writing, register file chosen
    apply(5'd3, 5'd4, 5'd3, 1'b0, 5'd4, 1'b0);
    chk("R1 idle sel_a", {30'd0, sel_a}, 32'd0);
    chk("R1 idle opnd_b", opnd_b, rf_val_b);

    // R2 operand A from EX/MEM
    apply(5'd7, 5'd9, 5'd7, 1'b1, 5'd1, 1'b1);
    chk("R2 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R2 opnd_a", opnd_a, exm_val);

    // R3 operand B from EX/MEM
    apply(5'd2, 5'd11, 5'd11, 1'b1, 5'd5, 1'b0);
    chk("R3 sel_b", {30'd0, sel_b}, 32'd2);
    chk("R3 sel_a", {30'd0, sel_a}, 32'd0);

    // R4 MEM/WB path for both operands, in separate cases
    apply(5'd6, 5'd8, 5'd12, 1'b1, 5'd6, 1'b1);
    chk("R4 sel_a", {30'd0, sel_a}, 32'd1);
    chk("R4 opnd_a", opnd_a, mwb_val);
    apply(5'd6, 5'd8, 5'd12, 1'b1, 5'd8, 1'b1);
    chk("R4 sel_b", {30'd0, sel_b}, 32'd1);

    // R5 both stages match operand A
    apply(5'd13, 5'd0, 5'd13, 1'b1, 5'd13, 1'b1);
    chk("R5 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R5 opnd_a", opnd_a, exm_val);

    // R6 write enables low with matching numbers
    apply(5'd14, 5'd14, 5'd14, 1'b0, 5'd14, 1'b0);
    chk("R6 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R6 opnd_b", opnd_b, rf_val_b);
    apply(5'd14, 5'd15, 5'd14, 1'b0, 5'd14, 1'b1);
    chk("R6 older stage used", {30'd0, sel_a}, 32'd1);

    // R7 register zero never forwarded
    apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R7 sel_a", {30'd0, sel_a}, 32'd0);
    chk("R7 sel_b", {30'd0, sel_b}, 32'd0);
    chk("R7 opnd_a", opnd_a, rf_val_a);

    // R8 same source on both operands, and mixed sources
    apply(5'd17, 5'd17, 5'd17, 1'b1, 5'd3, 1'b1);
    chk("R8 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R8 sel_b", {30'd0, sel_b}, 32'd2);
    apply(5'd18, 5'd19, 5'd18, 1'b1, 5'd19, 1'b1);
    chk("R8 mixed sel_a", {30'd0, sel_a}, 32'd2);
    chk("R8 mixed sel_b", {30'd0, sel_b}, 32'd1);
    chk("R8 mixed opnd_b", opnd_b, mwb_val);

    // R10 chain of three writes to r1: consumer sees newest
    apply(5'd1, 5'd4, 5'd1, 1'b1, 5'd1, 1'b1);
    chk("R10 sel_a", {30'd0, sel_a}, 32'd2);
    chk("R10 opnd_a", opnd_a, exm_val);

    // constrained random with narrow register range
    for (int i = 0; i < NRAND; i++) begin
      apply(5'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), 1'($urandom),
            5'($urandom % 4), 1'($urandom));
      full_check("R2 R3 R4 R5 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule